// File: doc/BRIEF.md
# Receive Byte Queue with Fill Trigger and Idle Timeout

This block buffers received serial characters between a bit-level receiver and a CPU read port. Each byte the receiver presents with `in_valid` is stored in a 16-entry first-in first-out queue while `rx_en` is high. The CPU removes the oldest byte by pulsing `pop`. The block reports the fill level on `fill_count` and raises `data_ready` once the fill level reaches a programmable trigger. If fewer bytes than the trigger have arrived, `data_ready` is also raised after the line has been idle for 15 character times. The trigger select is 2 bits wide and is taken from bits 7:6 of the serial port's FIFO control value.

Two small state machines make up the control. The ready-flag machine has the states RD_WAIT and RD_READY. It takes the transition *reach* (a push leaves the count at or above the trigger) or *expire* (the timeout ends) to RD_READY. It takes *drain* (a pop leaves the count below the trigger) or *flush* (`fifo_clr`) back to RD_WAIT. The timeout machine has the states TO_IDLE and TO_COUNT. It takes *arm* (a push that leaves the count below the trigger) into TO_COUNT, and *rearm* (another such push) stays in TO_COUNT with the counter at zero. It returns to TO_IDLE on *cancel* (a reaching push while the interrupt enable is on), *empty* (the queue becomes empty), *flush* or *expire*. `rx_irq` is the ready flag gated by `irq_en`.

Top module: `rx_trig_fifo`

## Requirements
- R1: The queue holds up to 16 bytes and returns them in arrival order, including after the read and write positions wrap from 15 back to 0.
- R2: The trigger select maps to these thresholds: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14.
- R3: A push that leaves the count at or above the trigger sets `data_ready` at the same clock edge that updates the count.
- R4: A pop on a non-empty queue presents the oldest byte on `pop_data` in the cycle `pop` is high and decrements the count. If the new count is below the trigger, `data_ready` clears.
- R5: A byte offered while the queue holds 16 entries is dropped, and the count stays at 16.
- R6: A byte offered while `rx_en` is low is not stored.
- R7: A pop on an empty queue shows 0 on `pop_data` and changes no state.
- R8: A push and a pop in the same cycle leave the count unchanged and return the oldest byte.
- R9: A push that leaves the count below the trigger restarts the idle timer from zero. After 15 `char_tick` pulses with no further push, `data_ready` is set.
- R10: The idle timer does not run while the queue is empty.
- R11: A pulse on `fifo_clr` empties the queue, zeroes the count and clears `data_ready`.
- R12: `rx_irq` equals `data_ready` while `irq_en` is high and is 0 otherwise. A reaching push with `irq_en` high cancels a running timeout; with `irq_en` low the timeout keeps running.
- R13: After reset the count is 0 and `data_ready` and `rx_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable; bytes are stored only while high |
| in_valid | input | 1 | Receiver strobe: `in_data` holds a byte |
| in_data | input | 8 | Received byte |
| pop | input | 1 | CPU read strobe; removes the oldest byte |
| pop_data | output | 8 | Oldest byte, or 0 when empty |
| trig_sel | input | 2 | Trigger select (0:1, 1:4, 2:8, 3:14 entries) |
| fifo_clr | input | 1 | Queue flush pulse |
| irq_en | input | 1 | Receive interrupt enable |
| char_tick | input | 1 | One pulse per character time |
| data_ready | output | 1 | Receive-data-ready flag |
| fill_count | output | 5 | Number of stored bytes, 0 to 16 |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Several properties are checked by assertions on every cycle:
- the count never exceeds the depth;
- a flush leaves the count and the flag at zero;
- a pop on an empty queue keeps the count;
- a simultaneous push and pop keep the count;
- a reaching push leaves the flag set;
- the timer only counts while the queue holds data.

Other behaviour can only be shown by the bench's scenarios:
- byte order across pointer wrap;
- each of the four trigger thresholds;
- the exact fifteenth-tick expiry and its restart by a later push;
- the difference between cancelled and uncancelled timeouts under the two interrupt-enable settings.

// File: rtl/rxq_pkg.sv
`timescale 1ns/100ps
package rxq_pkg;

    typedef enum logic {
        RD_WAIT  = 1'b0,
        RD_READY = 1'b1
    } ready_state_t;

    typedef enum logic {
        TO_IDLE  = 1'b0,
        TO_COUNT = 1'b1
    } tmo_state_t;

    // Threshold table for the 2-bit trigger select
    function automatic int unsigned trig_level(input logic [1:0] sel);
        unique case (sel)
            2'd0: trig_level = 1;
            2'd1: trig_level = 4;
            2'd2: trig_level = 8;
            default: trig_level = 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/100ps
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic                         pop,
    input  logic [WIDTH-1:0]             wr_data,
    output logic [WIDTH-1:0]             head_data,
    output logic [$clog2(DEPTH+1)-1:0]   occupancy,
    output logic                         push_ok,
    output logic                         pop_ok
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam bit POW2 = (DEPTH == (1 << PW));

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
    logic [CW-1:0]    cnt;

    generate
        if (POW2) begin : g_wrap_nat
            assign wr_ptr_nx = wr_ptr + 1'b1;
            assign rd_ptr_nx = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_ptr_nx = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_nx = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    assign push_ok   = push && (cnt != FULL_CNT);
    assign pop_ok    = pop && (cnt != '0);
    assign occupancy = cnt;
    assign head_data = (cnt != '0) ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr_nx;
            if (pop_ok)  rd_ptr <= rd_ptr_nx;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R5: the count never exceeds the depth
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
    // R11: a flush leaves the queue empty
    p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R7: a pop on an empty queue changes nothing
    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt == '0 && !push && !clr) |=> (cnt == '0));
    // R8: a simultaneous push and pop keep the count
    p_push_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok && !clr) |=> $stable(cnt));

endmodule

// File: rtl/rxq_timeout.sv
`timescale 1ns/100ps
module rxq_timeout #(
    parameter int LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic restart,
    input  logic cancel,
    input  logic drain,
    input  logic occupied,
    input  logic tick,
    output logic expire
);
    import rxq_pkg::*;

    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    tmo_state_t    state, state_d;
    logic [TW-1:0] ticks, ticks_d;

    // next-state logic
    always_comb begin
        state_d = state;
        ticks_d = ticks;
        if (clr) begin
            state_d = TO_IDLE;
            ticks_d = '0;
        end else if (restart) begin
            state_d = TO_COUNT;
            ticks_d = '0;
        end else begin
            unique case (state)
                TO_IDLE: ticks_d = '0;
                TO_COUNT: begin
                    if (cancel || drain) begin
                        state_d = TO_IDLE;
                        ticks_d = '0;
                    end else if (tick) begin
                        if (ticks == LAST) begin
                            state_d = TO_IDLE;
                            ticks_d = '0;
                        end else begin
                            ticks_d = ticks + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // output logic
    always_comb begin
        expire = 1'b0;
        unique case (state)
            TO_IDLE:  expire = 1'b0;
            TO_COUNT: expire = tick && (ticks == LAST) && !clr && !restart
                               && !cancel && !drain;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TO_IDLE;
            ticks <= '0;
        end else begin
            state <= state_d;
            ticks <= ticks_d;
        end
    end

    // R10: the timer only runs while the queue holds data
    p_idle_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TO_COUNT) |-> occupied);
    // R9: an expiry always ends the count
    p_expire_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state == TO_IDLE && ticks == '0));

endmodule

// File: rtl/rx_trig_fifo.sv
`timescale 1ns/100ps
module rx_trig_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int TIMEOUT_CHARS = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_en,
    input  logic                       in_valid,
    input  logic [WIDTH-1:0]           in_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           pop_data,
    input  logic [1:0]                 trig_sel,
    input  logic                       fifo_clr,
    input  logic                       irq_en,
    input  logic                       char_tick,
    output logic                       data_ready,
    output logic [$clog2(DEPTH+1)-1:0] fill_count,
    output logic                       rx_irq
);
    import rxq_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] occ, occ_nx, trig;
    logic          push_ok, pop_ok, reach, restart, expire;
    ready_state_t  rd_state, rd_state_d;

    rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (in_valid && rx_en),
        .pop       (pop),
        .wr_data   (in_data),
        .head_data (pop_data),
        .occupancy (occ),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok)
    );

    assign trig    = CW'(trig_level(trig_sel));
    assign occ_nx  = occ + CW'(push_ok) - CW'(pop_ok);
    assign reach   = push_ok && (occ_nx >= trig);
    assign restart = push_ok && !reach;

    rxq_timeout #(.LIMIT(TIMEOUT_CHARS)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fifo_clr),
        .restart  (restart),
        .cancel   (reach && irq_en),
        .drain    (occ_nx == '0),
        .occupied (occ != '0),
        .tick     (char_tick),
        .expire   (expire)
    );

    // ready-flag state machine: next state
    always_comb begin
        rd_state_d = rd_state;
        if (fifo_clr) begin
            rd_state_d = RD_WAIT;
        end else begin
            unique case (rd_state)
                RD_WAIT: begin
                    if (reach || expire) rd_state_d = RD_READY;
                end
                RD_READY: begin
                    if (!reach && pop_ok && occ_nx < trig) rd_state_d = RD_WAIT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_state <= RD_WAIT;
        else        rd_state <= rd_state_d;
    end

    // outputs
    always_comb begin
        unique case (rd_state)
            RD_WAIT:  data_ready = 1'b0;
            RD_READY: data_ready = 1'b1;
        endcase
        rx_irq     = data_ready && irq_en;
        fill_count = occ;
    end

    // R3: a push that reaches the trigger leaves the flag set
    p_reach_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !fifo_clr && (fill_count + 1'b1 - CW'(pop_ok)) >= trig) |=> data_ready);
    // R11: a flush clears the flag
    p_flush_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> !data_ready);
    // R12: no request without an enable
    p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !rx_irq);

endmodule

// File: tb/rx_trig_fifo_tb_top.sv
`timescale 1ns/100ps
module rx_trig_fifo_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic [1:0] trig_sel = 2'd0;
    logic       fifo_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       char_tick = 1'b0;
    logic       data_ready;
    logic [4:0] fill_count;
    logic       rx_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    rx_trig_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
        .in_data(in_data), .pop(pop), .pop_data(pop_data), .trig_sel(trig_sel),
        .fifo_clr(fifo_clr), .irq_en(irq_en), .char_tick(char_tick),
        .data_ready(data_ready), .fill_count(fill_count), .rx_irq(rx_irq)
    );

    // stimulus/expected table: trigger select and the threshold it must give
    localparam logic [1:0] SEL_TBL [4] = '{2'd0, 2'd1, 2'd2, 2'd3};
    localparam int         LVL_TBL [4] = '{1, 4, 8, 14};

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_b(input logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_data = b;
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic pop_b(output logic [7:0] b);
        @(negedge clk); b = pop_data; pop = 1'b1;
        @(negedge clk); pop = 1'b0;
    endtask

    task automatic push_pop(input logic [7:0] nb, output logic [7:0] b);
        @(negedge clk); b = pop_data; pop = 1'b1; in_valid = 1'b1; in_data = nb;
        @(negedge clk); pop = 1'b0; in_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); char_tick = 1'b1;
            @(negedge clk); char_tick = 1'b0;
        end
    endtask

    task automatic flush();
        @(negedge clk); fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13 count", int'(fill_count), 0);
        chk("R13 ready", int'(data_ready), 0);
        chk("R13 irq", int'(rx_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R4: table walk over the trigger thresholds
        for (int k = 0; k < 4; k++) begin
            flush();
            trig_sel = SEL_TBL[k];
            for (int j = 0; j < LVL_TBL[k] - 1; j++) push_b(8'(j + 1));
            if (LVL_TBL[k] > 1) chk("R2 below trigger", int'(data_ready), 0);
            push_b(8'h5A);
            chk("R2 count at trigger", int'(fill_count), LVL_TBL[k]);
            chk("R3 ready at trigger", int'(data_ready), 1);
            pop_b(got);
            chk("R4 ready clears", int'(data_ready), 0);
            chk("R4 count drop", int'(fill_count), LVL_TBL[k] - 1);
        end

        // R1/R5: fill to 16, overflow, drain in order
        flush();
        trig_sel = 2'd3;
        for (int i = 0; i < 16; i++) push_b(8'(i * 3 + 1));
        chk("R1 full count", int'(fill_count), 16);
        push_b(8'hEE);
        chk("R5 dropped", int'(fill_count), 16);
        for (int i = 0; i < 16; i++) begin
            pop_b(got);
            chk("R1 order", int'(got), i * 3 + 1);
        end
        chk("R1 drained", int'(fill_count), 0);

        // R7: pop on empty
        pop_b(got);
        chk("R7 empty data", int'(got), 0);
        chk("R7 empty count", int'(fill_count), 0);

        // R1: wrap of the positions
        for (int i = 0; i < 10; i++) push_b(8'(i));
        for (int i = 0; i < 10; i++) pop_b(got);
        for (int i = 0; i < 10; i++) push_b(8'(8'h80 + i));
        for (int i = 0; i < 10; i++) begin
            pop_b(got);
            chk("R1 wrap order", int'(got), 8'h80 + i);
        end

        // R6: receive disabled
        rx_en = 1'b0;
        push_b(8'h11);
        chk("R6 ignored", int'(fill_count), 0);
        rx_en = 1'b1;

        // R8: simultaneous push and pop
        push_b(8'hA1);
        push_b(8'hA2);
        push_pop(8'hA3, got);
        chk("R8 count", int'(fill_count), 2);
        chk("R8 data", int'(got), 8'hA1);
        pop_b(got);
        chk("R8 next", int'(got), 8'hA2);
        pop_b(got);
        chk("R8 last", int'(got), 8'hA3);

        // R9: timeout, then restart by a push
        flush();
        trig_sel = 2'd1;
        irq_en = 1'b1;
        push_b(8'h01);
        ticks(14);
        chk("R9 before expiry", int'(data_ready), 0);
        ticks(1);
        chk("R9 at expiry", int'(data_ready), 1);
        chk("R12 irq on", int'(rx_irq), 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R12 irq gated", int'(rx_irq), 0);
        flush();
        push_b(8'h01);
        ticks(10);
        push_b(8'h02);
        ticks(14);
        chk("R9 restarted", int'(data_ready), 0);
        ticks(1);
        chk("R9 restart expiry", int'(data_ready), 1);

        // R10: timer idle when empty
        flush();
        push_b(8'h03);
        pop_b(got);
        ticks(20);
        chk("R10 no expiry", int'(data_ready), 0);

        // R12: cancel with enable on
        flush();
        irq_en = 1'b1;
        for (int i = 0; i < 4; i++) push_b(8'(i));
        chk("R12 irq reach", int'(rx_irq), 1);
        pop_b(got);
        chk("R12 irq cleared", int'(rx_irq), 0);
        ticks(16);
        chk("R12 cancelled", int'(data_ready), 0);

        // R12: no cancel with enable off
        flush();
        irq_en = 1'b0;
        for (int i = 0; i < 4; i++) push_b(8'(i));
        pop_b(got);
        chk("R12 drop below", int'(data_ready), 0);
        ticks(15);
        chk("R12 uncancelled", int'(data_ready), 1);

        // R11: flush
        flush();
        chk("R11 count", int'(fill_count), 0);
        chk("R11 ready", int'(data_ready), 0);

        finish_run();
    end

endmodule